// File: doc/BRIEF.md
# HI/LO Multiply-Divide Accumulator

This unit sits beside the integer pipeline of a 32-bit RISC core and owns a persistent 64-bit accumulator split into a high word (HI) and a low word (LO). Each cycle it can accept one decoded operation with two register operands. The operation can be a signed or unsigned multiply into HI/LO, a multiply-add or multiply-subtract against the accumulator, or a signed or unsigned divide. It can also be a three-operand multiply that hands back only the low word, or a move to or from either half.

Multiplies and accumulates finish one cycle after issue. Divides run a bit-serial restoring algorithm over the operand magnitudes and hold `busy` high while they run. The requester holds off new work while `busy` is high. A read of HI or LO that arrives during a divide is still captured. It is answered once the divide has written back. Values read from HI or LO, and the low word of the three-operand multiply, leave the unit on a single registered result port.

Top module: `muldiv_acc`

## Requirements
- R1: With `op_space`=0, function 0x18 (signed) or 0x19 (unsigned) writes the 64-bit product of `op_a` and `op_b`: the upper word to HI and the lower word to LO.
- R2: With `op_space`=1, function 0x00 (signed) or 0x01 (unsigned) sets {HI,LO} to {HI,LO} plus the product. Function 0x04 (signed) or 0x05 (unsigned) sets {HI,LO} to {HI,LO} minus the product. The sum or difference is kept modulo 2^64.
- R3: With `op_space`=0, function 0x1A (signed) or 0x1B (unsigned) with a nonzero `op_b` raises `busy` on the following cycle. `busy` stays high for exactly 32 cycles, and then LO holds the quotient and HI the remainder. A signed quotient truncates toward zero, and a signed remainder takes the sign of the dividend.
- R4: A divide whose `op_b` is zero leaves HI and LO unchanged and never raises `busy`.
- R5: With `op_space`=1, function 0x02 returns the low 32 bits of the signed product on `res_data`, with `res_valid` high, one cycle after issue. HI and LO are left unchanged.
- R6: With `op_space`=0, functions 0x11 and 0x13 load `op_a` into HI and LO respectively. Functions 0x10 and 0x12 return HI and LO respectively on `res_data`, with `res_valid` high, one cycle after issue.
- R7: A read of HI or LO that is presented while a divide runs is not answered at once. It is answered with the post-divide value in the cycle after the divide writes back. `busy` stays high until that answer appears.
- R8: Any operation other than a read that is presented while `busy` is high is ignored. HI and LO do not change until the divide writes back.
- R9: A function code not listed in R1, R2, R3, R5 or R6 is ignored and changes neither HI nor LO.
- R10: After reset HI and LO are zero, and `busy` and `res_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_space | input | 1 | Function space: 0 = primary, 1 = secondary |
| op_func | input | 6 | Function code within the space |
| op_a | input | 32 | First register operand (dividend, source for moves) |
| op_b | input | 32 | Second register operand (divisor) |
| busy | output | 1 | Divide in progress or deferred read pending |
| res_valid | output | 1 | `res_data` carries a result this cycle |
| res_data | output | 32 | HI/LO read value or low product word |

## Verification
Two things can land in the same cycle: the final iteration of a divide writing HI/LO, and a read of HI or LO. The bench provokes this by presenting a read, plus a move into HI, in the cycles straight after issuing a divide. It then judges that the read returns the post-divide quotient rather than the older LO, and that a later read of HI shows the remainder untouched by the move. A scoreboard queue checks the order of results, so an early or duplicated answer to the deferred read shows up as a mismatch.

// File: rtl/muldiv_acc.sv
module muldiv_acc #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic            op_space,
  input  logic [5:0]      op_func,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  output logic            busy,
  output logic            res_valid,
  output logic [XLEN-1:0] res_data
);
  localparam int DW = 2 * XLEN;
  localparam int CW = $clog2(XLEN);
  localparam logic [CW-1:0] LAST = CW'(XLEN - 1);

  localparam logic [5:0] F_MFHI  = 6'h10;
  localparam logic [5:0] F_MTHI  = 6'h11;
  localparam logic [5:0] F_MFLO  = 6'h12;
  localparam logic [5:0] F_MTLO  = 6'h13;
  localparam logic [5:0] F_MULT  = 6'h18;
  localparam logic [5:0] F_MULTU = 6'h19;
  localparam logic [5:0] F_DIV   = 6'h1A;
  localparam logic [5:0] F_DIVU  = 6'h1B;
  localparam logic [5:0] F_MADD  = 6'h00;
  localparam logic [5:0] F_MADDU = 6'h01;
  localparam logic [5:0] F_MUL3  = 6'h02;
  localparam logic [5:0] F_MSUB  = 6'h04;
  localparam logic [5:0] F_MSUBU = 6'h05;

  logic [XLEN-1:0] hi_q, lo_q;
  logic            div_q;
  logic [CW-1:0]   cnt_q;
  logic [XLEN-1:0] rem_q, quo_q, dvs_q;
  logic            negq_q, negr_q;
  logic            pend_q, pend_hi_q;

  assign busy = div_q | pend_q;

  wire take = op_valid & ~busy;
  wire sp1  = ~op_space;
  wire sp2  = op_space;

  wire d_mfhi  = sp1 & (op_func == F_MFHI);
  wire d_mflo  = sp1 & (op_func == F_MFLO);
  wire d_mthi  = sp1 & (op_func == F_MTHI);
  wire d_mtlo  = sp1 & (op_func == F_MTLO);
  wire d_rd    = d_mfhi | d_mflo;
  wire d_mulhl = sp1 & ((op_func == F_MULT) | (op_func == F_MULTU));
  wire d_div   = sp1 & ((op_func == F_DIV) | (op_func == F_DIVU));
  wire d_add   = sp2 & ((op_func == F_MADD) | (op_func == F_MADDU));
  wire d_sub   = sp2 & ((op_func == F_MSUB) | (op_func == F_MSUBU));
  wire d_mul3  = sp2 & (op_func == F_MUL3);

  // every signed variant in both spaces has an even function code
  wire sgn = ~op_func[0];

  wire [DW-1:0] ext_a = sgn ? {{XLEN{op_a[XLEN-1]}}, op_a} : {{XLEN{1'b0}}, op_a};
  wire [DW-1:0] ext_b = sgn ? {{XLEN{op_b[XLEN-1]}}, op_b} : {{XLEN{1'b0}}, op_b};
  wire [DW-1:0] prod  = ext_a * ext_b;
  wire [DW-1:0] acc   = {hi_q, lo_q};
  wire [DW-1:0] acc_add = acc + prod;
  wire [DW-1:0] acc_sub = acc - prod;

  wire            a_neg = sgn & op_a[XLEN-1];
  wire            b_neg = sgn & op_b[XLEN-1];
  wire [XLEN-1:0] mag_a = a_neg ? -op_a : op_a;
  wire [XLEN-1:0] mag_b = b_neg ? -op_b : op_b;
  wire            b_zero = (op_b == '0);

  wire [XLEN:0]   shifted = {rem_q, quo_q[XLEN-1]};
  wire [XLEN:0]   trial   = shifted - {1'b0, dvs_q};
  wire            fit     = ~trial[XLEN];
  wire [XLEN-1:0] rem_n   = fit ? trial[XLEN-1:0] : shifted[XLEN-1:0];
  wire [XLEN-1:0] quo_n   = {quo_q[XLEN-2:0], fit};
  wire            div_last = div_q & (cnt_q == LAST);
  wire [XLEN-1:0] q_out   = negq_q ? -quo_n : quo_n;
  wire [XLEN-1:0] r_out   = negr_q ? -rem_n : rem_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q      <= '0;
      lo_q      <= '0;
      div_q     <= 1'b0;
      cnt_q     <= '0;
      rem_q     <= '0;
      quo_q     <= '0;
      dvs_q     <= '0;
      negq_q    <= 1'b0;
      negr_q    <= 1'b0;
      pend_q    <= 1'b0;
      pend_hi_q <= 1'b0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= 1'b0;
      if (div_q) begin
        cnt_q <= cnt_q + 1'b1;
        rem_q <= rem_n;
        quo_q <= quo_n;
        if (div_last) begin
          div_q <= 1'b0;
          hi_q  <= r_out;
          lo_q  <= q_out;
        end
      end
      if (op_valid && div_q && d_rd && !pend_q) begin
        pend_q    <= 1'b1;
        pend_hi_q <= d_mfhi;
      end
      if (pend_q && !div_q) begin
        pend_q    <= 1'b0;
        res_valid <= 1'b1;
        res_data  <= pend_hi_q ? hi_q : lo_q;
      end
      if (take) begin
        if (d_rd) begin
          res_valid <= 1'b1;
          res_data  <= d_mfhi ? hi_q : lo_q;
        end
        if (d_mthi) hi_q <= op_a;
        if (d_mtlo) lo_q <= op_a;
        if (d_mulhl) {hi_q, lo_q} <= prod;
        if (d_add)   {hi_q, lo_q} <= acc_add;
        if (d_sub)   {hi_q, lo_q} <= acc_sub;
        if (d_mul3) begin
          res_valid <= 1'b1;
          res_data  <= prod[XLEN-1:0];
        end
        if (d_div && !b_zero) begin
          div_q  <= 1'b1;
          cnt_q  <= '0;
          rem_q  <= '0;
          quo_q  <= mag_a;
          dvs_q  <= mag_b;
          negq_q <= a_neg ^ b_neg;
          negr_q <= a_neg;
        end
      end
    end
  end

  // R3
  div_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && d_div && !b_zero) |=> (busy && !res_valid));

  // R4
  zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && d_div && b_zero) |=> (!busy && $stable(hi_q) && $stable(lo_q)));

  // R5
  mul_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && d_mul3) |=> (res_valid && $stable(hi_q) && $stable(lo_q)));

  // R8
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q && !div_last) |=> (busy && $stable(hi_q) && $stable(lo_q)));

  // R7
  pend_ans_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !div_q) |=> (res_valid && !pend_q));

endmodule

// File: tb/muldiv_acc_tb.sv
`timescale 1ns/1ps
module muldiv_acc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_space = 1'b0;
  logic [5:0]  op_func = '0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        busy, res_valid;
  logic [31:0] res_data;

  muldiv_acc u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_space(op_space),
    .op_func(op_func), .op_a(op_a), .op_b(op_b),
    .busy(busy), .res_valid(res_valid), .res_data(res_data)
  );

  always #10 clk = ~clk;

  typedef struct { logic [31:0] d; string tag; } exp_t;
  exp_t sbq[$];
  exp_t cur;
  int total = 0;
  int bad = 0;
  logic [31:0] m_hi = '0, m_lo = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (sbq.size() == 0) begin
        total++;
        bad++;
        $display("FAIL R6 unexpected result act=%h exp=none", res_data);
      end else begin
        cur = sbq.pop_front();
        chk(res_data === cur.d, cur.tag, {32'h0, res_data}, {32'h0, cur.d});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R3 watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic issue(input logic sp, input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op_valid = 1'b1; op_space = sp; op_func = f; op_a = a; op_b = b;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic rd(input bit hi, input string tag);
    exp_t e;
    e.d = hi ? m_hi : m_lo;
    e.tag = tag;
    sbq.push_back(e);
    issue(1'b0, hi ? 6'h10 : 6'h12, 32'h0, 32'h0);
  endtask

  function automatic logic [63:0] mprod(input bit s, input logic [31:0] a, input logic [31:0] b);
    if (s) return 64'(longint'($signed(a)) * longint'($signed(b)));
    return {32'h0, a} * {32'h0, b};
  endfunction

  task automatic acc_op(input logic sp, input logic [5:0] f, input logic [31:0] a, input logic [31:0] b, input string tag);
    logic [63:0] p;
    p = mprod(!f[0], a, b);
    if (!sp) {m_hi, m_lo} = p;
    else if (f[2]) {m_hi, m_lo} = {m_hi, m_lo} - p;
    else {m_hi, m_lo} = {m_hi, m_lo} + p;
    issue(sp, f, a, b);
    rd(1'b1, tag);
    rd(1'b0, tag);
  endtask

  task automatic do_div(input bit s, input logic [31:0] a, input logic [31:0] b, input string tag);
    int n;
    issue(1'b0, s ? 6'h1A : 6'h1B, a, b);
    if (b == 0) begin
      chk(busy == 1'b0, "R4", {63'h0, busy}, 64'h0);
    end else begin
      n = 0;
      while (busy) begin n++; @(negedge clk); end
      chk(n == 32, "R3", 64'(n), 64'd32);
      if (s) begin
        m_lo = $signed(a) / $signed(b);
        m_hi = $signed(a) % $signed(b);
      end else begin
        m_lo = a / b;
        m_hi = a % b;
      end
    end
    rd(1'b1, tag);
    rd(1'b0, tag);
  endtask

  initial begin
    exp_t e;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R10", {63'h0, busy}, 64'h0);
    chk(res_valid == 1'b0, "R10", {63'h0, res_valid}, 64'h0);
    rst_n = 1'b1;
    rd(1'b1, "R10");
    rd(1'b0, "R10");

    issue(1'b0, 6'h11, 32'h1234_5678, 32'h0); m_hi = 32'h1234_5678;
    issue(1'b0, 6'h13, 32'h9abc_def0, 32'h0); m_lo = 32'h9abc_def0;
    rd(1'b1, "R6");
    rd(1'b0, "R6");

    acc_op(1'b0, 6'h18, 32'hffff_fffd, 32'd7, "R1");
    acc_op(1'b0, 6'h19, 32'hffff_ffff, 32'd2, "R1");
    acc_op(1'b0, 6'h18, 32'h8000_0000, 32'h8000_0000, "R1");
    acc_op(1'b1, 6'h00, 32'hffff_fffe, 32'd5, "R2");
    acc_op(1'b1, 6'h01, 32'hffff_fffe, 32'd5, "R2");
    acc_op(1'b1, 6'h04, 32'h0001_0000, 32'hffff_0003, "R2");
    acc_op(1'b1, 6'h05, 32'h0001_0000, 32'hffff_0003, "R2");

    e.d = 32'(longint'(-6) * longint'(123456)); e.tag = "R5";
    sbq.push_back(e);
    issue(1'b1, 6'h02, 32'hffff_fffa, 32'd123456);
    rd(1'b1, "R5");
    rd(1'b0, "R5");

    do_div(1'b1, 32'd100, 32'hffff_fff9, "R3");
    do_div(1'b1, 32'hffff_ff9c, 32'd7, "R3");
    do_div(1'b0, 32'hffff_ffff, 32'd16, "R3");
    do_div(1'b0, 32'h8000_0000, 32'd3, "R3");
    do_div(1'b1, 32'd55, 32'h0, "R4");
    do_div(1'b0, 32'd55, 32'h0, "R4");

    // divide, then a move and a read while it runs
    issue(1'b0, 6'h1A, 32'd1000, 32'd33);
    issue(1'b0, 6'h11, 32'hdead_beef, 32'h0);
    m_lo = 32'd30;
    m_hi = 32'd10;
    e.d = m_lo; e.tag = "R7";
    sbq.push_back(e);
    issue(1'b0, 6'h12, 32'h0, 32'h0);
    chk(res_valid == 1'b0, "R7", {63'h0, res_valid}, 64'h0);
    chk(busy == 1'b1, "R7", {63'h0, busy}, 64'h1);
    while (busy) @(negedge clk);
    rd(1'b1, "R8");
    rd(1'b0, "R8");

    issue(1'b0, 6'h3F, 32'h1111_1111, 32'h2222_2222);
    issue(1'b1, 6'h03, 32'h1111_1111, 32'h2222_2222);
    issue(1'b0, 6'h00, 32'h1111_1111, 32'h2222_2222);
    rd(1'b1, "R9");
    rd(1'b0, "R9");

    repeat (5) @(negedge clk);
    chk(sbq.size() == 0, "R6", 64'(sbq.size()), 64'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule